// File: doc/BRIEF.md
# Performance Counter Bank with Master Cycle Counter

This block is a small bank of event counters that watches a DRAM controller. Slot 0 always counts clock cycles and acts as the master of the bank. Each of slots 1 and up counts one event, picked by an 8-bit code from a parallel vector of single-cycle event strobes. The strobe at vector index k carries event code k. Typical codes are 0x04 for read accesses, 0x05 for write accesses, 0x20 and 0x21 for read and write commands, 0x31 for precharge, 0x32 for activate and 0x37 for refresh.

Software reaches the bank through a plain 32-bit register port. It has a write strobe with an address and data, and a separate read address with combinational read data. The master slot gates the whole bank. While its enable is low, or while its overflow flag is set, no slot counts. When the master wraps past its maximum value it raises its sticky overflow flag. The whole bank then stops and the interrupt output goes high. An event slot that wraps keeps counting and only records its own flag.

The counter width is a parameter (32 bits by default), and counter values read back zero-extended. Software takes deltas modulo 2^width.

Top module: `perf_counter_bank`

## Requirements
- R1: After reset, every control word and every counter reads 0 and `irq` is low.
- R2: Address decoding works as follows.
  - Control word n is at byte address 4*n. Counter n is read at 0x20 + 4*n.
  - The two low address bits are ignored.
  - Any other address reads 0.
  - Writes to counter addresses have no effect.
  - The control word layout is: bit 0 overflow flag, bit 1 clear, bit 2 enable, bits 31:24 event code. All other bits read 0.
- R3: Slot 0 advances by one on every clock edge at which its enable is 1 and its overflow flag is 0. Its event code field always reads 0.
- R4: Slot n ≥ 1 advances by one on an edge at which all of the following hold: its enable is 1, the master is running, and `evt_strobe[code]` is 1. A code of NUM_EVT or more never counts.
- R5: While the master enable is 0, every counter holds its value. Setting the master enable again resumes counting from the held values.
- R6: When slot 0 wraps to 0, the following happens together.
  - Its overflow flag is set and every counter stops.
  - `irq` follows the level of that flag.
  - Writing 0 to bit 0 of control word 0 clears the flag and the bank resumes. Writing 1 to that bit leaves the flag unchanged.
- R7: When slot n ≥ 1 wraps, it goes on counting from 0 and sets its own overflow flag. `irq` and the other slots are not affected.
- R8: Slot 0 is zeroed only by a write whose clear bit is 1 while its stored clear bit is 0. A write with the clear bit at 1 while the stored bit is already 1 leaves the count alone.
- R9: For slot n ≥ 1, a write with the clear bit at 0 zeroes the counter. The stored clear bit reads 1 after any write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (8) | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W (8) | Byte address of the read |
| rd_data | output | 32 | Combinational read data |
| evt_strobe | input | NUM_EVT (64) | One-cycle event strobes, indexed by event code |
| irq | output | 1 | Level of the master overflow flag |

## Verification
A control write takes effect at the clock edge that samples it. Counting first uses the new enable on the following edge, so a counting window opened at edge E and closed by a write at edge F counts F−E edges. Read data is combinational, so a value written or counted at an edge shows on `rd_data` in the low phase right after it. The checks drive inputs and sample outputs in the low phase. During timed runs they issue only writes and waits, and they read counters only once the bank is frozen or halted, so every expected count comes from edge arithmetic on the windows.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
   localparam int DATA_W         = 32;
   localparam int SEL_W          = 8;
   localparam int OVF_BIT        = 0;
   localparam int CLR_BIT        = 1;
   localparam int EN_BIT         = 2;
   localparam int SEL_LSB        = 24;
   localparam int CTRL_WORD_BASE = 0;
   localparam int CNT_WORD_BASE  = 8;

   typedef struct packed {
      logic [SEL_W-1:0] sel;
      logic             en;
      logic             clr;
      logic             ovf;
   } ctrl_t;

   function automatic logic [DATA_W-1:0] pack_ctrl(input ctrl_t c);
      logic [DATA_W-1:0] v;
      v                   = '0;
      v[SEL_LSB +: SEL_W] = c.sel;
      v[EN_BIT]           = c.en;
      v[CLR_BIT]          = c.clr;
      v[OVF_BIT]          = c.ovf;
      return v;
   endfunction
endpackage

// File: rtl/pcb_ctrl_reg.sv
module pcb_ctrl_reg
   import pcb_pkg::*;
#(
   parameter bit IS_MASTER = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              ovf_set_i,
   output ctrl_t             ctrl_o,
   output logic              clr_pulse_o
);
   logic             en_q;
   logic             clr_q;
   logic             ovf_q;
   logic [SEL_W-1:0] sel_w;

   // enable and sticky overflow: a write may only lower the flag, hardware raises it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         ovf_q <= 1'b0;
      end else begin
         if (wr_i) en_q <= wdata_i[EN_BIT];
         ovf_q <= (wr_i ? (ovf_q & wdata_i[OVF_BIT]) : ovf_q) | ovf_set_i;
      end
   end

   generate
      if (IS_MASTER) begin : g_master
         logic unused_wbits;
         assign unused_wbits = ^{wdata_i[DATA_W-1:EN_BIT+1]};

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    clr_q <= 1'b0;
            else if (wr_i) clr_q <= wdata_i[CLR_BIT];
         end
         assign sel_w       = '0;
         assign clr_pulse_o = wr_i & wdata_i[CLR_BIT] & ~clr_q;

         assert_ovf_sticky_R6 : assert property (@(posedge clk) disable iff (!rst_n)
            (ovf_q && !wr_i) |=> ovf_q);
      end else begin : g_event
         logic [SEL_W-1:0] sel_q;
         logic             unused_wbits;
         assign unused_wbits = ^{wdata_i[SEL_LSB-1:EN_BIT+1]};

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               clr_q <= 1'b0;
               sel_q <= '0;
            end else if (wr_i) begin
               clr_q <= 1'b1;
               sel_q <= wdata_i[SEL_LSB +: SEL_W];
            end
         end
         assign sel_w       = sel_q;
         assign clr_pulse_o = wr_i & ~wdata_i[CLR_BIT];

         assert_clr_return_R9 : assert property (@(posedge clk) disable iff (!rst_n)
            wr_i |=> clr_q);
      end
   endgenerate

   assign ctrl_o = '{sel: sel_w, en: en_q, clr: clr_q, ovf: ovf_q};
endmodule

// File: rtl/pcb_counter.sv
module pcb_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             inc_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             wrap_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clr_i)  cnt_q <= '0;
      else if (inc_i)  cnt_q <= cnt_q + CNT_W'(1);
   end

   assign cnt_o  = cnt_q;
   assign wrap_o = inc_i & ~clr_i & (&cnt_q);

   assert_hold_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !inc_i) |=> $stable(cnt_q));
   assert_step_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !clr_i) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
endmodule

// File: rtl/pcb_read_mux.sv
module pcb_read_mux
   import pcb_pkg::*;
#(
   parameter int NUM_CNT = 4,
   parameter int CNT_W   = 32,
   parameter int ADDR_W  = 8
) (
   input  logic [ADDR_W-1:0]               rd_addr_i,
   input  ctrl_t [NUM_CNT-1:0]             ctrl_i,
   input  logic [NUM_CNT-1:0][CNT_W-1:0]   cnt_i,
   output logic [DATA_W-1:0]               rdata_o
);
   localparam int WORD_W = ADDR_W - 2;

   logic [WORD_W-1:0] word;
   logic              unused_lo;
   assign word      = rd_addr_i[ADDR_W-1:2];
   assign unused_lo = ^rd_addr_i[1:0];

   always_comb begin
      rdata_o = '0;
      for (int i = 0; i < NUM_CNT; i++) begin
         if (word == WORD_W'(CTRL_WORD_BASE + i)) rdata_o = pack_ctrl(ctrl_i[i]);
         if (word == WORD_W'(CNT_WORD_BASE + i))  rdata_o[CNT_W-1:0] = cnt_i[i];
      end
   end
endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank
   import pcb_pkg::*;
#(
   parameter int NUM_CNT = 4,
   parameter int CNT_W   = 32,
   parameter int NUM_EVT = 64,
   parameter int ADDR_W  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [31:0]        wr_data,
   input  logic [ADDR_W-1:0]  rd_addr,
   output logic [31:0]        rd_data,
   input  logic [NUM_EVT-1:0] evt_strobe,
   output logic               irq
);
   localparam int WORD_W = ADDR_W - 2;
   localparam int IDX_W  = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;
   localparam logic [SEL_W:0] EVT_LIMIT = (SEL_W + 1)'(NUM_EVT);

   generate
      if (NUM_CNT < 2 || NUM_CNT > 8) begin : g_bad_cnt
         $error("NUM_CNT must be in 2..8");
      end
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_width
         $error("CNT_W must be in 2..32");
      end
      if (NUM_EVT < 2 || NUM_EVT > (1 << SEL_W)) begin : g_bad_evt
         $error("NUM_EVT must be in 2..256");
      end
      if (ADDR_W < 6) begin : g_bad_addr
         $error("ADDR_W must be at least 6");
      end
   endgenerate

   ctrl_t [NUM_CNT-1:0]           ctrl;
   logic  [NUM_CNT-1:0][CNT_W-1:0] cnt;
   logic  [NUM_CNT-1:0]           wr_sel;
   logic  [NUM_CNT-1:0]           clr_pulse;
   logic  [NUM_CNT-1:0]           wrap;
   logic  [WORD_W-1:0]            wr_word;
   logic                          run;
   logic                          unused_wlo;

   assign wr_word    = wr_addr[ADDR_W-1:2];
   assign unused_wlo = ^wr_addr[1:0];
   // the master gates the whole bank
   assign run        = ctrl[0].en & ~ctrl[0].ovf;
   assign irq        = ctrl[0].ovf;

   generate
      for (genvar g = 0; g < NUM_CNT; g++) begin : g_slot
         logic inc;

         assign wr_sel[g] = wr_en && (wr_word == WORD_W'(CTRL_WORD_BASE + g));

         pcb_ctrl_reg #(.IS_MASTER(g == 0)) u_ctrl (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_i        (wr_sel[g]),
            .wdata_i     (wr_data),
            .ovf_set_i   (wrap[g]),
            .ctrl_o      (ctrl[g]),
            .clr_pulse_o (clr_pulse[g])
         );

         if (g == 0) begin : g_cycles
            assign inc = run;
         end else begin : g_events
            logic hit;
            assign hit = ({1'b0, ctrl[g].sel} < EVT_LIMIT) &&
                         evt_strobe[ctrl[g].sel[IDX_W-1:0]];
            assign inc = ctrl[g].en & run & hit;
         end

         pcb_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr_i  (clr_pulse[g]),
            .inc_i  (inc),
            .cnt_o  (cnt[g]),
            .wrap_o (wrap[g])
         );
      end
   endgenerate

   pcb_read_mux #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_rd (
      .rd_addr_i (rd_addr),
      .ctrl_i    (ctrl),
      .cnt_i     (cnt),
      .rdata_o   (rd_data)
   );

   assert_irq_cause_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(wrap[0]));
   assert_halted_bank_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl[0].ovf && !wr_en) |=> $stable(cnt));
   assert_frozen_bank_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl[0].en && !wr_en) |=> $stable(cnt));
   assert_quiet_wrap_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (!wrap[0] && !wr_en) |=> $stable(irq));
endmodule

// File: tb/sim_perf_counter_bank.sv
module sim_perf_counter_bank;
   localparam int CLK_PERIOD = 10;
   localparam int CW         = 8;

   typedef struct packed {
      logic [7:0]  s1, s2, s3;
      logic [63:0] stb;
      logic [15:0] n;
      logic [7:0]  e0, e1, e2, e3;
   } row_t;

   // event codes, strobe pattern, window length, expected counts
   localparam row_t ROWS [4] = '{
      '{8'h04, 8'h05, 8'h20, 64'h0000_0001_0000_0010, 16'd10, 8'd10, 8'd10, 8'd0,  8'd10},
      '{8'h31, 8'h32, 8'h37, 64'h0084_0000_0000_0000, 16'd7,  8'd7,  8'd0,  8'd7,  8'd7 },
      '{8'h21, 8'h21, 8'h05, 64'h0000_0002_0000_0000, 16'd5,  8'd5,  8'd5,  8'd5,  8'd0 },
      '{8'h04, 8'h40, 8'h3F, 64'hFFFF_FFFF_FFFF_FFFF, 16'd3,  8'd3,  8'd3,  8'd0,  8'd3 }
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [7:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic [63:0] evt = '0;
   logic        irq;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   perf_counter_bank #(.NUM_CNT(4), .CNT_W(CW), .NUM_EVT(64), .ADDR_W(8)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .evt_strobe(evt), .irq(irq)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk);
      #1 wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      rd_addr = a;
      #1 check(tag, rd_data, exp);
   endtask

   function automatic logic [31:0] ev_ctrl(input logic [7:0] sel);
      return {sel, 21'b0, 3'b100};
   endfunction

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: reset state
      for (int i = 0; i < 4; i++) begin
         rd(8'(4*i), 32'h0, "R1 control after reset");
         rd(8'(8'h20 + 4*i), 32'h0, "R1 counter after reset");
      end
      check("R1 irq after reset", {31'b0, irq}, 32'h0);

      // table of counting windows (R3, R4, R5)
      for (int r = 0; r < 4; r++) begin
         wr(8'h00, 32'h0);
         evt = ROWS[r].stb;
         wr(8'h04, ev_ctrl(ROWS[r].s1));
         wr(8'h08, ev_ctrl(ROWS[r].s2));
         wr(8'h0C, ev_ctrl(ROWS[r].s3));
         wr(8'h00, 32'h6);
         repeat (int'(ROWS[r].n) - 1) @(posedge clk);
         wr(8'h00, 32'h0);
         repeat (3) @(posedge clk);
         rd(8'h20, {24'b0, ROWS[r].e0}, "R3 cycle count over window");
         rd(8'h24, {24'b0, ROWS[r].e1}, "R4 event slot 1");
         rd(8'h28, {24'b0, ROWS[r].e2}, "R4 event slot 2");
         rd(8'h2C, {24'b0, ROWS[r].e3}, "R4 event slot 3");
      end
      rd(8'h04, 32'h0400_0006, "R2 control layout slot 1");

      // R5: resume from held values
      wr(8'h00, 32'h4);
      repeat (3) @(posedge clk);
      wr(8'h00, 32'h0);
      rd(8'h20, 32'd7, "R5 master resumed from held value");
      rd(8'h24, 32'd7, "R5 event slot resumed");

      // R8: master clear needs a 0 to 1 transition of the clear bit
      wr(8'h00, 32'h2);
      rd(8'h20, 32'd0, "R8 master cleared on clear rise");
      wr(8'h00, 32'h6);
      @(posedge clk);
      wr(8'h00, 32'h2);
      rd(8'h20, 32'd2, "R8 repeated clear bit does not clear");
      rd(8'h24, 32'd9, "R4 slot 1 kept counting");

      // R9: event slot clear by writing 0
      wr(8'h04, 32'h0400_0000);
      rd(8'h24, 32'd0, "R9 slot 1 zeroed by clear 0");
      rd(8'h04, 32'h0400_0002, "R9 clear bit returns to 1");

      // R2: writes to counter address ignored, unmapped reads 0
      wr(8'h24, 32'h0000_00FF);
      rd(8'h24, 32'd0, "R2 counter write ignored");
      rd(8'h10, 32'd0, "R2 unmapped address");
      rd(8'h01, 32'h0000_0002, "R2 low address bits ignored");

      // R7: event slot wraps silently
      wr(8'h00, 32'h0);
      evt = 64'h10;
      wr(8'h04, 32'h0400_0004);
      wr(8'h00, 32'h6);
      repeat (199) @(posedge clk);
      wr(8'h00, 32'h4);
      wr(8'h00, 32'h6);
      repeat (99) @(posedge clk);
      wr(8'h00, 32'h0);
      rd(8'h20, 32'd100, "R8 master cleared mid run");
      rd(8'h24, 32'd45, "R7 slot 1 wrapped and kept counting");
      rd(8'h04, 32'h0400_0007, "R7 slot 1 overflow flag");
      check("R7 no irq on slot wrap", {31'b0, irq}, 32'h0);

      // R6: master wrap halts bank
      wr(8'h04, 32'h0400_0006);
      evt = '0;
      wr(8'h00, 32'h6);
      repeat (56) @(posedge clk);
      @(negedge clk) evt = 64'h10;
      repeat (200) @(posedge clk);
      repeat (10) @(posedge clk);
      rd(8'h20, 32'd0, "R6 master wrapped and halted");
      rd(8'h24, 32'd245, "R6 slot 1 halted");
      rd(8'h00, 32'h0000_0007, "R6 master overflow flag");
      rd(8'h04, 32'h0400_0006, "R6 slot 1 flag cleared by write");
      check("R6 irq on master wrap", {31'b0, irq}, 32'h1);

      // R6: clearing the flag resumes; R3 code field of slot 0 reads 0
      wr(8'h00, 32'hFF00_0006);
      @(negedge clk);
      #1 check("R6 irq dropped", {31'b0, irq}, 32'h0);
      rd_addr = 8'h00;
      #1 check("R3 master code field reads 0", rd_data, 32'h0000_0006);
      wr(8'h00, 32'h0);
      rd(8'h20, 32'd2, "R6 master resumed");
      rd(8'h24, 32'd247, "R6 slot 1 resumed");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule